// File: doc/BRIEF.md
# Multi-cycle 16-bit load-store core

A compact processor core that walks through a program held in a word-addressed synchronous memory. Every instruction is one 16-bit word. The top two bits choose one of four formats: flag control, register set, memory access and arithmetic. The core keeps eight 16-bit registers and two status flags, zero and carry. Index 0 always reads as zero. Index 6 is conventionally the stack pointer. Index 7 is the program counter, so any write to it acts as a jump.

Branching has no instruction of its own. The arithmetic opcode carries a condition field, and an operation whose condition fails leaves the registers and flags untouched. Writing the program counter through such an operation gives a conditional jump. The arithmetic is done by a separate conditional ALU block.

Instructions take two clock cycles, fetch and execute. A load takes one extra cycle to wait for the returned data. A halt instruction freezes the core until the next reset. A debug port reads any register at any time without side effects.

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high at a clock edge, all registers, both flags and the halted state clear. The first fetch after reset is from address 0, and `halted` is low.
- R2: Register index 0 always reads 0. Writes to it from set, load or ALU instructions are discarded.
- R3: Instruction bits [15:14] select the format: 00 control, 01 set, 10 memory, 11 ALU.
- R4: The set format writes the zero-extended value in bits [10:0] to the register named in bits [13:11]. It leaves the flags unchanged.
- R5: The memory format forms a word address from the base register in bits [10:8] plus the sign-extended 7-bit offset in bits [6:0]. When bit 7 is 1, it loads that word into the register in bits [13:11]. When bit 7 is 0, it stores that register's value with `mem_we` high for exactly one cycle.
- R6: ALU bits [1:0] pick the operation on src1 (bits [10:8]) and src2 (bits [7:5]): 00 add, 01 subtract, 10 add with carry-in, 11 subtract with borrow-in. The result goes to bits [13:11]. Carry becomes the carry out of an add or the borrow of a subtract, and zero becomes result==0.
- R7: ALU bits [4:2] give the condition: 000 always, 001 zero set, 010 zero clear, 011 carry set, 100 carry clear, 101 to 111 never. When the condition fails, no register or flag changes.
- R8: The control format uses bits [2:0]: 001 sets zero, 010 clears zero, 011 sets carry, 100 clears carry. Codes 101, 110 and 111 change nothing.
- R9: Control code 000 halts the core. `halted` stays high, no fetch or store takes place, and the program counter holds until reset.
- R10: The program counter advances by one in every fetch. An instruction that reads index 7 sees the address of the next instruction. A write to index 7 replaces the advanced value, so the next fetch comes from the written address.
- R11: A non-load instruction takes two cycles and a load takes three. The memory returns read data one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt has executed |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Value of the selected register |

## Verification
The assertions assume a memory that answers each address with its data on the following cycle, and a reset held high from time zero until after the first clock edge. The bench keeps to both. It drives `rst` high before any edge and releases it only between edges. It models the memory with a registered read that returns each word one cycle after the address. The `dbg_sel` input is changed only between edges, and only after the core halts or while reset is held.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
   localparam int unsigned WORD_W  = 16;
   localparam int unsigned REG_CNT = 8;

   typedef enum logic [1:0] {
      FMT_CTL = 2'b00,
      FMT_SET = 2'b01,
      FMT_MEM = 2'b10,
      FMT_ALU = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      ST_FETCH,
      ST_EXEC,
      ST_WAIT,
      ST_HALT
   } state_e;

   localparam logic [2:0] CTL_HALT = 3'b000;
   localparam logic [2:0] CTL_ZSET = 3'b001;
   localparam logic [2:0] CTL_ZCLR = 3'b010;
   localparam logic [2:0] CTL_CSET = 3'b011;
   localparam logic [2:0] CTL_CCLR = 3'b100;
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
   parameter int unsigned W       = 16,
   parameter int unsigned DEPTH   = 8,
   parameter bit          PC_LAST = 1'b1,
   localparam int unsigned IW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_val,
   input  logic          pc_step,
   input  logic [IW-1:0] rd_a_idx,
   output logic [W-1:0]  rd_a,
   input  logic [IW-1:0] rd_b_idx,
   output logic [W-1:0]  rd_b,
   input  logic [IW-1:0] rd_c_idx,
   output logic [W-1:0]  rd_c,
   output logic [W-1:0]  pc_out
);
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("mc16_regfile: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign q[i] = '0;
      end else if (PC_LAST && i == DEPTH - 1) begin : g_pc
         logic [W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)                                r <= '0;
            else if (wr_en && wr_idx == IW'(i))     r <= wr_val;
            else if (pc_step)                       r <= r + {{(W-1){1'b0}}, 1'b1};
         end
         assign q[i] = r;

         // R10: a fetch without a competing write advances the counter by one
         assert_pc_step_R10: assert property (@(posedge clk) disable iff (rst)
            (pc_step && !(wr_en && wr_idx == IW'(i))) |=>
            (pc_out == $past(pc_out) + {{(W-1){1'b0}}, 1'b1}));
      end else begin : g_gp
         logic [W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)                            r <= '0;
            else if (wr_en && wr_idx == IW'(i)) r <= wr_val;
         end
         assign q[i] = r;
      end
   end

   assign rd_a   = q[rd_a_idx];
   assign rd_b   = q[rd_b_idx];
   assign rd_c   = q[rd_c_idx];
   assign pc_out = q[DEPTH-1];

   // R2: the zero register never reads anything else
   assert_zero_reg_R2: assert property (@(posedge clk) disable iff (rst)
      (rd_c_idx == '0) |-> (rd_c == '0));
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu #(
   parameter int unsigned W   = 16,
   parameter int unsigned OPW = 5
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic [OPW-1:0] op,
   input  logic           z_in,
   input  logic           c_in,
   output logic [W-1:0]   y,
   output logic           z_out,
   output logic           c_out,
   output logic           take
);
   if (OPW != 5) begin : g_bad_opw
      $error("mc16_alu: operation field must be 5 bits");
   end

   logic [2:0] cond;
   logic [1:0] kind;
   logic       cin;
   logic [W:0] wide;

   assign cond = op[4:2];
   assign kind = op[1:0];
   assign cin  = kind[1] & c_in;

   always_comb begin
      unique case (cond)
         3'b000:  take = 1'b1;
         3'b001:  take = z_in;
         3'b010:  take = ~z_in;
         3'b011:  take = c_in;
         3'b100:  take = ~c_in;
         default: take = 1'b0;
      endcase
   end

   always_comb begin
      if (kind[0]) wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      else         wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   end

   assign y     = wide[W-1:0];
   assign c_out = wide[W];
   assign z_out = (wide[W-1:0] == '0);
endmodule

// File: rtl/mc16_core.sv
module mc16_core
   import mc16_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned REG_NUM = 8,
   localparam int unsigned IDX_W  = $clog2(REG_NUM)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   input  logic [IDX_W-1:0]  dbg_sel,
   output logic [DATA_W-1:0] dbg_data
);
   if (DATA_W != WORD_W || REG_NUM != REG_CNT) begin : g_bad_cfg
      $error("mc16_core: encoding fixes 16-bit words and eight registers");
   end

   state_e            state_q, state_d;
   logic              zf_q, cf_q;
   logic [IDX_W-1:0]  ld_idx_q;

   fmt_e              fmt;
   logic [IDX_W-1:0]  f_rd, f_rs1, f_rs2;
   logic [DATA_W-1:0] imm_z, off_s;

   assign fmt   = fmt_e'(mem_rdata[15:14]);
   assign f_rd  = mem_rdata[13:11];
   assign f_rs1 = mem_rdata[10:8];
   assign f_rs2 = mem_rdata[7:5];
   assign imm_z = {{(DATA_W-11){1'b0}}, mem_rdata[10:0]};
   assign off_s = {{(DATA_W-7){mem_rdata[6]}}, mem_rdata[6:0]};

   logic              rf_we, pc_step;
   logic [IDX_W-1:0]  rf_widx, rf_bidx;
   logic [DATA_W-1:0] rf_wval, opa, opb, pc;

   logic [DATA_W-1:0] alu_y;
   logic              alu_z, alu_c, alu_take;

   assign rf_bidx = (fmt == FMT_MEM) ? f_rd : f_rs2;

   mc16_regfile #(.W(DATA_W), .DEPTH(REG_NUM), .PC_LAST(1'b1)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (rf_we),
      .wr_idx   (rf_widx),
      .wr_val   (rf_wval),
      .pc_step  (pc_step),
      .rd_a_idx (f_rs1),
      .rd_a     (opa),
      .rd_b_idx (rf_bidx),
      .rd_b     (opb),
      .rd_c_idx (dbg_sel),
      .rd_c     (dbg_data),
      .pc_out   (pc)
   );

   mc16_alu #(.W(DATA_W), .OPW(5)) u_alu (
      .a     (opa),
      .b     (opb),
      .op    (mem_rdata[4:0]),
      .z_in  (zf_q),
      .c_in  (cf_q),
      .y     (alu_y),
      .z_out (alu_z),
      .c_out (alu_c),
      .take  (alu_take)
   );

   always_comb begin
      state_d   = state_q;
      rf_we     = 1'b0;
      rf_widx   = f_rd;
      rf_wval   = '0;
      pc_step   = 1'b0;
      mem_addr  = pc;
      mem_wdata = opb;
      mem_we    = 1'b0;
      unique case (state_q)
         ST_FETCH: begin
            pc_step = 1'b1;
            state_d = ST_EXEC;
         end
         ST_EXEC: begin
            state_d = ST_FETCH;
            unique case (fmt)
               FMT_CTL: if (mem_rdata[2:0] == CTL_HALT) state_d = ST_HALT;
               FMT_SET: begin
                  rf_we   = 1'b1;
                  rf_wval = imm_z;
               end
               FMT_MEM: begin
                  mem_addr = opa + off_s;
                  if (mem_rdata[7]) state_d = ST_WAIT;
                  else              mem_we  = 1'b1;
               end
               FMT_ALU: begin
                  rf_we   = alu_take;
                  rf_wval = alu_y;
               end
               default: ;
            endcase
         end
         ST_WAIT: begin
            rf_we   = 1'b1;
            rf_widx = ld_idx_q;
            rf_wval = mem_rdata;
            state_d = ST_FETCH;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_FETCH;
         zf_q     <= 1'b0;
         cf_q     <= 1'b0;
         ld_idx_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_EXEC) begin
            ld_idx_q <= f_rd;
            if (fmt == FMT_CTL) begin
               unique case (mem_rdata[2:0])
                  CTL_ZSET: zf_q <= 1'b1;
                  CTL_ZCLR: zf_q <= 1'b0;
                  CTL_CSET: cf_q <= 1'b1;
                  CTL_CCLR: cf_q <= 1'b0;
                  default: ;
               endcase
            end else if (fmt == FMT_ALU && alu_take) begin
               zf_q <= alu_z;
               cf_q <= alu_c;
            end
         end
      end
   end

   assign halted = (state_q == ST_HALT);

   // R1: leaving reset starts at address zero, not halted
   assert_reset_start_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (mem_addr == '0 && !halted));
   // R9: halt is sticky and silent
   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && !mem_we && $stable(mem_addr)));
   // R5: a store strobe lasts a single cycle
   assert_store_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);
   // R11: the load wait state only follows an execute cycle and returns to fetch
   assert_load_wait_R11: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WAIT) |=> (state_q == ST_FETCH && $past(state_q, 2) == ST_EXEC));
endmodule

// File: tb/test_mc16_core.sv
module test_mc16_core;
   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
   logic        mem_we, halted;
   logic [2:0]  dbg_sel = 3'd0;

   logic [15:0] mem [256];
   int          compared = 0;
   int          mismatched = 0;
   int          pa = 0;

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   mc16_core i_mc16_core (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
      .dbg_sel(dbg_sel), .dbg_data(dbg_data)
   );

   function automatic logic [15:0] e_ctl(logic [2:0] o);
      return {2'b00, 11'd0, o};
   endfunction
   function automatic logic [15:0] e_set(logic [2:0] d, logic [10:0] v);
      return {2'b01, d, v};
   endfunction
   function automatic logic [15:0] e_mem(logic [2:0] d, logic [2:0] b, logic ld, logic [6:0] off);
      return {2'b10, d, b, ld, off};
   endfunction
   function automatic logic [15:0] e_alu(logic [2:0] d, logic [2:0] s1, logic [2:0] s2, logic [4:0] op);
      return {2'b11, d, s1, s2, op};
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(logic [2:0] idx, output logic [15:0] v);
      dbg_sel = idx;
      #1;
      v = dbg_data;
   endtask

   task automatic chk_reg(string req, logic [2:0] idx, logic [15:0] exp);
      logic [15:0] v;
      rd(idx, v);
      chk(req, v, exp);
   endtask

   task automatic put(logic [15:0] w);
      mem[pa] = w;
      pa++;
   endtask

   task automatic start_load;
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      pa = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic run(output int edges);
      rst = 1'b0;
      edges = 0;
      while (!halted && edges < 2000) begin
         @(posedge clk);
         edges++;
         @(negedge clk);
      end
   endtask

   task automatic t_set_and_halt;
      int   n;
      logic [15:0] a0;
      start_load();
      put(e_set(3'd1, 11'h7FF));
      put(e_set(3'd0, 11'd5));
      put(e_set(3'd6, 11'h400));
      put(e_ctl(3'b000));
      run(n);
      chk("R11 cycles for four plain instructions", 16'(n), 16'd8);
      chk_reg("R4 set zero-extends", 3'd1, 16'h07FF);
      chk_reg("R3 set format selected", 3'd6, 16'h0400);
      chk_reg("R2 write to index 0 dropped", 3'd0, 16'h0000);
      a0 = mem_addr;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R9 no store while halted", {15'd0, mem_we}, 16'd0);
         chk("R9 address frozen while halted", mem_addr, a0);
      end
      chk("R9 halted stays high", {15'd0, halted}, 16'd1);
      chk_reg("R9 pc holds after halt", 3'd7, 16'd4);
   endtask

   task automatic t_reset;
      int n;
      start_load();
      put(e_ctl(3'b011));
      put(e_ctl(3'b001));
      put(e_set(3'd5, 11'h321));
      put(e_ctl(3'b000));
      run(n);
      chk_reg("R4 set before reset", 3'd5, 16'h0321);
      start_load();
      chk("R1 halted low in reset", {15'd0, halted}, 16'd0);
      chk("R1 fetch address zero in reset", mem_addr, 16'h0000);
      chk_reg("R1 register cleared", 3'd5, 16'h0000);
      chk_reg("R1 pc cleared", 3'd7, 16'h0000);
      put(e_set(3'd3, 11'd7));
      put(e_alu(3'd1, 3'd3, 3'd0, 5'b01010));
      put(e_ctl(3'b000));
      run(n);
      chk_reg("R1 flags cleared by reset (adc-if-not-zero)", 3'd1, 16'd7);
   endtask

   task automatic t_alu_basic;
      int n;
      start_load();
      put(e_set(3'd1, 11'd5));
      put(e_set(3'd2, 11'd7));
      put(e_alu(3'd3, 3'd1, 3'd2, 5'b00001));
      put(e_alu(3'd4, 3'd0, 3'd0, 5'b00010));
      put(e_alu(3'd5, 3'd2, 3'd1, 5'b00011));
      put(e_alu(3'd0, 3'd1, 3'd1, 5'b00001));
      put(e_alu(3'd6, 3'd1, 3'd2, 5'b00100));
      put(e_alu(3'd5, 3'd1, 3'd1, 5'b00100));
      put(e_alu(3'd1, 3'd2, 3'd2, 5'b01000));
      put(e_ctl(3'b000));
      run(n);
      chk("R11 cycles for ten plain instructions", 16'(n), 16'd20);
      chk_reg("R6 subtract wraps", 3'd3, 16'hFFFE);
      chk_reg("R6 borrow fed into add-with-carry", 3'd4, 16'd1);
      chk_reg("R7 skipped op leaves dst", 3'd5, 16'd2);
      chk_reg("R7 if-zero taken after zero result", 3'd6, 16'd12);
      chk_reg("R7 if-not-zero taken", 3'd1, 16'd14);
      chk_reg("R2 compare into index 0 discarded", 3'd0, 16'd0);
   endtask

   task automatic t_alu_carry;
      int n;
      start_load();
      put(e_set(3'd2, 11'd1));
      put(e_alu(3'd1, 3'd0, 3'd2, 5'b00001));
      put(e_alu(3'd3, 3'd1, 3'd2, 5'b00000));
      put(e_alu(3'd4, 3'd0, 3'd0, 5'b00010));
      put(e_ctl(3'b011));
      put(e_alu(3'd5, 3'd2, 3'd0, 5'b00011));
      put(e_ctl(3'b000));
      run(n);
      chk_reg("R6 zero minus one", 3'd1, 16'hFFFF);
      chk_reg("R6 add wraps to zero", 3'd3, 16'h0000);
      chk_reg("R6 add carry out used by adc", 3'd4, 16'd1);
      chk_reg("R6 sbc with borrow-in", 3'd5, 16'd0);
   endtask

   task automatic t_flags;
      int n;
      start_load();
      put(e_ctl(3'b011));
      put(e_alu(3'd1, 3'd0, 3'd0, 5'b00010));
      put(e_alu(3'd2, 3'd0, 3'd0, 5'b00010));
      put(e_alu(3'd3, 3'd1, 3'd1, 5'b01100));
      put(e_ctl(3'b011));
      put(e_alu(3'd3, 3'd1, 3'd1, 5'b01100));
      put(e_ctl(3'b001));
      put(e_alu(3'd4, 3'd1, 3'd0, 5'b00100));
      put(e_ctl(3'b001));
      put(e_ctl(3'b010));
      put(e_alu(3'd5, 3'd1, 3'd1, 5'b00100));
      put(e_ctl(3'b110));
      put(e_ctl(3'b111));
      put(e_ctl(3'b101));
      put(e_alu(3'd6, 3'd1, 3'd1, 5'b00100));
      put(e_alu(3'd6, 3'd1, 3'd1, 5'b01100));
      put(e_ctl(3'b011));
      put(e_ctl(3'b100));
      put(e_alu(3'd5, 3'd3, 3'd3, 5'b10000));
      put(e_alu(3'd4, 3'd1, 3'd1, 5'b10100));
      put(e_ctl(3'b011));
      put(e_alu(3'd4, 3'd1, 3'd1, 5'b11100));
      put(e_ctl(3'b000));
      run(n);
      chk_reg("R8 set carry then adc", 3'd1, 16'd1);
      chk_reg("R6 zero result from adc", 3'd2, 16'd0);
      chk_reg("R7 if-carry after carry set", 3'd3, 16'd2);
      chk_reg("R8 set zero enables if-zero", 3'd4, 16'd1);
      chk_reg("R8 clear carry enables if-not-carry", 3'd5, 16'd4);
      chk_reg("R8 reserved codes leave flags clear", 3'd6, 16'd0);
   endtask

   task automatic t_memory;
      int n;
      start_load();
      put(e_set(3'd1, 11'd100));
      put(e_set(3'd2, 11'h123));
      put(e_mem(3'd2, 3'd1, 1'b0, 7'h7C));
      put(e_mem(3'd3, 3'd1, 1'b1, 7'h7C));
      put(e_mem(3'd4, 3'd0, 1'b1, 7'd10));
      put(e_mem(3'd4, 3'd1, 1'b0, 7'd5));
      put(e_mem(3'd0, 3'd0, 1'b1, 7'd10));
      put(e_ctl(3'b000));
      mem[10] = 16'hBEEF;
      run(n);
      chk("R11 three loads add three cycles", 16'(n), 16'd19);
      chk("R5 store with negative offset", mem[96], 16'h0123);
      chk_reg("R5 load back", 3'd3, 16'h0123);
      chk_reg("R5 load from zero base", 3'd4, 16'hBEEF);
      chk("R5 store with positive offset", mem[105], 16'hBEEF);
      chk_reg("R2 load into index 0 dropped", 3'd0, 16'h0000);
   endtask

   task automatic t_jump;
      int n;
      start_load();
      put(e_set(3'd1, 11'd1));
      put(e_set(3'd7, 11'd4));
      put(e_set(3'd1, 11'h55));
      put(e_ctl(3'b000));
      put(e_set(3'd2, 11'd9));
      put(e_alu(3'd3, 3'd7, 3'd0, 5'b00000));
      put(e_set(3'd4, 11'd3));
      put(e_alu(3'd7, 3'd0, 3'd4, 5'b00000));
      put(e_set(3'd5, 11'd1));
      run(n);
      chk("R10 seven instructions on the taken path", 16'(n), 16'd14);
      chk_reg("R10 jump skipped instruction", 3'd1, 16'd1);
      chk_reg("R10 landed at jump target", 3'd2, 16'd9);
      chk_reg("R10 pc read gives next address", 3'd3, 16'd6);
      chk_reg("R10 alu jump skipped tail", 3'd5, 16'd0);
      chk_reg("R10 pc after halt at 3", 3'd7, 16'd4);
   endtask

   initial begin
      #(CLK_P * 200000);
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      t_set_and_halt();
      t_reset();
      t_alu_basic();
      t_alu_carry();
      t_flags();
      t_memory();
      t_jump();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule